// File: doc/BRIEF.md
# USART Clock Generation Unit

This block produces the timing enables that a serial transmitter and receiver need, all in the system clock domain. A reloadable down-counter divides the system clock by the programmed divisor plus one. A post-divider then forms the transmit rate from that tick, with the ratio set by the operating mode. In asynchronous operation the receiver takes the undivided divider tick as its oversampling base. In synchronous operation both directions share one bit clock.

Four modes are supported: normal-speed asynchronous, double-speed asynchronous, synchronous master and synchronous slave. In master mode the block drives a serial clock onto a pin, with selectable polarity. In slave mode it samples that pin through a synchronizer, detects the chosen edge and turns each detected edge into a one-cycle tick. Every tick output is a single-cycle enable and never a derived clock.

Top module: `usart_clkgen`

## Requirements
- R1: In both asynchronous modes, `rx_tick` pulses for one cycle every `div_val`+1 system clocks, while no write occurs.
- R2: A cycle with `div_lo_wr` high loads the counter with `div_val` at once and discards the count in progress. No divider tick appears in that cycle. The next divider tick appears `div_val`+1 cycles after the write cycle.
- R3: In normal asynchronous mode (`sync_mode`=0, `dbl_speed`=0), `tx_tick` has a period of 16×(`div_val`+1) cycles and coincides with an `rx_tick`.
- R4: In double-speed asynchronous mode (`sync_mode`=0, `dbl_speed`=1), `tx_tick` has a period of 8×(`div_val`+1) cycles.
- R5: In synchronous master mode (`sync_mode`=1, `pin_dir`=1), `tx_tick` and `rx_tick` are the same pulse, with a period of 2×(`div_val`+1) cycles, whatever the value of `dbl_speed`.
- R6: In synchronous master mode, `xck_out` changes only right after a divider tick. It equals NOT `clk_pol` in a cycle that carries `tx_tick`, and equals `clk_pol` in the cycle that follows it.
- R7: `xck_oe` is high only in synchronous master mode. It is low in both asynchronous modes and in slave mode.
- R8: In synchronous slave mode (`sync_mode`=1, `pin_dir`=0), `tx_tick` and `rx_tick` pulse together for one cycle per qualifying edge on `xck_in`: a rising edge when `clk_pol`=0, a falling edge when `clk_pol`=1. The pulse falls in the second cycle after the cycle in which the pin changed. The other edge produces no tick, and the divider produces no tick on these outputs.
- R9: While reset is held, `tx_tick` and `xck_oe` are low. The counter starts from zero, so with a zero divisor `rx_tick` is high in the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | 12 | Baud divisor; the counter reload value |
| div_lo_wr | input | 1 | Strobe for a write to the divisor low byte; reloads the counter |
| sync_mode | input | 1 | 1 selects synchronous operation, 0 asynchronous |
| dbl_speed | input | 1 | Double-speed select, used in asynchronous operation only |
| pin_dir | input | 1 | In synchronous operation: 1 for master (drives the pin), 0 for slave |
| clk_pol | input | 1 | Clock polarity: selects the slave sampling edge and inverts the master output |
| xck_in | input | 1 | Pad input of the serial clock pin |
| xck_out | output | 1 | Drive value for the serial clock pin |
| xck_oe | output | 1 | Output enable for the serial clock pin |
| tx_tick | output | 1 | Single-cycle transmit bit-rate enable |
| rx_tick | output | 1 | Single-cycle receiver base enable |

## Verification
On every cycle, the assertions check these invariants:
- a low-byte write suppresses the divider tick;
- a nonzero divisor leaves a quiet cycle after each tick and after a write;
- an asynchronous transmit tick always coincides with a receive tick;
- the pin stays undriven outside synchronous operation;
- the master pin changes only after a divider tick;
- a slave tick matches the pin history through the synchronizer.

Only the bench scenarios can show the exact periods for each mode and divisor. The same holds for the position of the first tick after a reload that interrupts a long count, the fact that the double-speed bit has no effect in master mode, and the polarity phase of the master clock around a transmit tick.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

   typedef enum logic [1:0] {
      MODE_ASYNC_NORM  = 2'd0,
      MODE_ASYNC_DBL   = 2'd1,
      MODE_SYNC_MASTER = 2'd2,
      MODE_SYNC_SLAVE  = 2'd3
   } clk_mode_e;

   function automatic clk_mode_e decode_mode(input logic sync_sel,
                                             input logic dbl_sel,
                                             input logic drive_sel);
      if (!sync_sel)
         return dbl_sel ? MODE_ASYNC_DBL : MODE_ASYNC_NORM;
      return drive_sel ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
   endfunction

endpackage

// File: rtl/usart_baud_divider.sv
module usart_baud_divider #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] load_val,
   input  logic             load_stb,
   output logic             tick
);

   generate
      if (DIV_W < 2 || DIV_W > 24) begin : g_bad_width
         $error("usart_baud_divider: DIV_W out of range");
      end
   endgenerate

   logic [DIV_W-1:0] count_q;
   logic             at_zero;

   assign at_zero = (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= '0;
      else if (load_stb || at_zero)
         count_q <= load_val;
      else
         count_q <= count_q - 1'b1;
   end

   assign tick = at_zero && !load_stb;

endmodule

// File: rtl/usart_post_divider.sv
module usart_post_divider
   import usart_clkgen_pkg::*;
#(
   parameter int NORM_RATIO = 16,
   parameter int DBL_RATIO  = 8,
   parameter int SYNC_RATIO = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      base_tick,
   input  clk_mode_e mode,
   output logic      tx_tick,
   output logic      phase
);

   localparam int PW = (NORM_RATIO > 2) ? $clog2(NORM_RATIO) : 1;
   localparam logic [PW-1:0] NORM_LIM  = PW'(NORM_RATIO - 1);
   localparam logic [PW-1:0] DBL_LIM   = PW'(DBL_RATIO - 1);
   localparam logic [PW-1:0] SYNC_LIM  = PW'(SYNC_RATIO - 1);
   localparam logic [PW-1:0] HALF_MARK = PW'(SYNC_RATIO / 2);

   generate
      if (!(NORM_RATIO >= DBL_RATIO && DBL_RATIO >= SYNC_RATIO && SYNC_RATIO >= 2)) begin : g_bad_ratio
         $error("usart_post_divider: ratios must satisfy NORM >= DBL >= SYNC >= 2");
      end
   endgenerate

   logic [PW-1:0] pcnt_q;
   logic [PW-1:0] limit;
   logic          wrap;

   always_comb begin
      case (mode)
         MODE_ASYNC_NORM: limit = NORM_LIM;
         MODE_ASYNC_DBL:  limit = DBL_LIM;
         default:         limit = SYNC_LIM;
      endcase
   end

   assign wrap = (pcnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pcnt_q <= '0;
      else if (base_tick)
         pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
   end

   assign tx_tick = base_tick && wrap;
   assign phase   = (pcnt_q >= HALF_MARK);

endmodule

// File: rtl/usart_edge_sync.sv
module usart_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic fall_sel,
   output logic edge_tick
);

   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("usart_edge_sync: STAGES must be 2 to 4");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;
   logic              synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign synced    = chain_q[STAGES-1];
   assign edge_tick = fall_sel ? (!synced && last_q) : (synced && !last_q);

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
   import usart_clkgen_pkg::*;
#(
   parameter int DIV_W       = 12,
   parameter int NORM_RATIO  = 16,
   parameter int DBL_RATIO   = 8,
   parameter int SYNC_RATIO  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_val,
   input  logic             div_lo_wr,
   input  logic             sync_mode,
   input  logic             dbl_speed,
   input  logic             pin_dir,
   input  logic             clk_pol,
   input  logic             xck_in,
   output logic             xck_out,
   output logic             xck_oe,
   output logic             tx_tick,
   output logic             rx_tick
);

   clk_mode_e mode;
   logic      base_tick;
   logic      post_tick;
   logic      post_phase;
   logic      slave_tick;

   assign mode = decode_mode(sync_mode, dbl_speed, pin_dir);

   usart_baud_divider #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_val (div_val),
      .load_stb (div_lo_wr),
      .tick     (base_tick)
   );

   usart_post_divider #(
      .NORM_RATIO (NORM_RATIO),
      .DBL_RATIO  (DBL_RATIO),
      .SYNC_RATIO (SYNC_RATIO)
   ) u_post (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_tick (base_tick),
      .mode      (mode),
      .tx_tick   (post_tick),
      .phase     (post_phase)
   );

   usart_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin       (xck_in),
      .fall_sel  (clk_pol),
      .edge_tick (slave_tick)
   );

   always_comb begin
      case (mode)
         MODE_ASYNC_NORM,
         MODE_ASYNC_DBL: begin
            tx_tick = post_tick;
            rx_tick = base_tick;
         end
         MODE_SYNC_MASTER: begin
            tx_tick = post_tick;
            rx_tick = post_tick;
         end
         default: begin
            tx_tick = slave_tick;
            rx_tick = slave_tick;
         end
      endcase
   end

   assign xck_oe  = (mode == MODE_SYNC_MASTER);
   assign xck_out = ((mode == MODE_SYNC_MASTER) && post_phase) ^ clk_pol;

endmodule

// File: rtl/usart_clkgen_chk.sv
module usart_clkgen_chk #(
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] div_val,
   input logic             div_lo_wr,
   input logic             sync_mode,
   input logic             pin_dir,
   input logic             clk_pol,
   input logic             xck_in,
   input logic             xck_out,
   input logic             xck_oe,
   input logic             tx_tick,
   input logic             rx_tick,
   input logic             base_tick
);

   logic [1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age_q <= 2'd0;
      else if (age_q != 2'd3)
         age_q <= age_q + 2'd1;
   end

   assert_async_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_mode |-> !xck_oe);

   assert_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (div_lo_wr && !sync_mode) |-> !rx_tick);

   assert_write_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (div_lo_wr && div_val != '0) |=> !base_tick);

   assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (base_tick && !div_lo_wr && div_val != '0) |=> !base_tick);

   assert_tx_on_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_tick && !sync_mode) |-> rx_tick);

   assert_master_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((sync_mode && pin_dir) && $past(sync_mode && pin_dir) && $stable(clk_pol)
       && !$stable(xck_out)) |-> $past(base_tick));

   generate
      if (SYNC_STAGES == 2) begin : g_slave_chk
         assert_slave_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd3 && sync_mode && !pin_dir && !clk_pol && rx_tick)
            |-> ($past(xck_in, 2) && !$past(xck_in, 3)));

         assert_slave_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (age_q == 2'd3 && sync_mode && !pin_dir && clk_pol && rx_tick)
            |-> (!$past(xck_in, 2) && $past(xck_in, 3)));
      end
   endgenerate

endmodule

bind usart_clkgen usart_clkgen_chk #(
   .DIV_W       (DIV_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .div_val   (div_val),
   .div_lo_wr (div_lo_wr),
   .sync_mode (sync_mode),
   .pin_dir   (pin_dir),
   .clk_pol   (clk_pol),
   .xck_in    (xck_in),
   .xck_out   (xck_out),
   .xck_oe    (xck_oe),
   .tx_tick   (tx_tick),
   .rx_tick   (rx_tick),
   .base_tick (base_tick)
);

// File: tb/usart_clkgen_test.sv
`timescale 1ns/1ps
module usart_clkgen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] div_val = '0;
   logic        div_lo_wr = 1'b0;
   logic        sync_mode = 1'b0;
   logic        dbl_speed = 1'b0;
   logic        pin_dir = 1'b0;
   logic        clk_pol = 1'b0;
   logic        xck_in = 1'b0;
   logic        xck_out, xck_oe, tx_tick, rx_tick;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #5 clk = ~clk;

   usart_clkgen uut (
      .clk(clk), .rst_n(rst_n), .div_val(div_val), .div_lo_wr(div_lo_wr),
      .sync_mode(sync_mode), .dbl_speed(dbl_speed), .pin_dir(pin_dir),
      .clk_pol(clk_pol), .xck_in(xck_in), .xck_out(xck_out), .xck_oe(xck_oe),
      .tx_tick(tx_tick), .rx_tick(rx_tick)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // mode: 0 normal async, 1 double async, 2 master
   function automatic int exp_tx_period(input int mode, input int d);
      if (mode == 0) return 16 * (d + 1);
      if (mode == 1) return 8 * (d + 1);
      return 2 * (d + 1);
   endfunction

   function automatic int exp_rx_period(input int mode, input int d);
      if (mode == 2) return 2 * (d + 1);
      return d + 1;
   endfunction

   function automatic logic sig(input int which);
      return (which == 0) ? rx_tick : tx_tick;
   endfunction

   task automatic configure(input int d, input logic s, input logic db,
                            input logic dir, input logic pol);
      step();
      sync_mode = s; dbl_speed = db; pin_dir = dir; clk_pol = pol;
      div_val = 12'(d); div_lo_wr = 1'b1;
      #1;
      if (!s) check("R2 no tick in write cycle", int'(rx_tick), 0);
      step();
      div_lo_wr = 1'b0;
   endtask

   task automatic find_tick(input int which);
      for (int k = 0; k < 2000; k++) begin
         if (sig(which)) break;
         step();
      end
   endtask

   task automatic measure(input int which, input int period, input string req);
      find_tick(which);
      for (int r = 0; r < 2; r++) begin
         int n = 0;
         do begin
            step();
            n++;
         end while (!sig(which) && n < 2000);
         check(req, n, period);
      end
   endtask

   task automatic slave_edge(input logic lvl, input logic expect_tick);
      step();
      xck_in = lvl;
      step();
      check("R8 no tick one cycle after pin change", int'(rx_tick | tx_tick), 0);
      step();
      check("R8 rx tick two cycles after pin change", int'(rx_tick), int'(expect_tick));
      check("R8 tx tick two cycles after pin change", int'(tx_tick), int'(expect_tick));
      for (int k = 0; k < 3; k++) begin
         step();
         check("R8 single cycle slave tick", int'(rx_tick | tx_tick), 0);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) step();
      check("R9 tx tick low in reset", int'(tx_tick), 0);
      check("R9 pin not driven in reset", int'(xck_oe), 0);
      rst_n = 1'b1;
      step();
      check("R9 counter starts at zero", int'(rx_tick), 1);

      // R2: reload in the middle of a long count
      configure(30, 0, 0, 0, 0);
      repeat (10) step();
      div_val = 12'd5; div_lo_wr = 1'b1;
      #1;
      check("R2 write suppresses tick", int'(rx_tick), 0);
      begin
         int k = 0;
         step();
         div_lo_wr = 1'b0;
         k = 1;
         while (!rx_tick && k < 100) begin
            step();
            k++;
         end
         check("R2 first tick after reload", k, 6);
      end

      // directed: each mode at a fixed divisor
      configure(3, 0, 0, 0, 0);
      check("R7 no drive in normal async", int'(xck_oe), 0);
      measure(0, 4, "R1 rx period normal async");
      measure(1, 64, "R3 tx period normal async");
      configure(2, 0, 1, 0, 0);
      check("R7 no drive in double async", int'(xck_oe), 0);
      measure(0, 3, "R1 rx period double async");
      measure(1, 24, "R4 tx period double async");
      configure(4, 1, 1, 1, 0);
      check("R7 drive in master", int'(xck_oe), 1);
      measure(1, 10, "R5 tx period master with double bit set");
      measure(0, 10, "R5 rx period master");

      // R6: master clock phase for both polarities
      for (int p = 0; p < 2; p++) begin
         configure(3, 1, 0, 1, p[0]);
         find_tick(1);
         check("R6 master out with tx tick", int'(xck_out), int'(!p[0]));
         step();
         check("R6 master out after tx tick", int'(xck_out), p);
         step(); step(); step();
         check("R6 master out held until divider tick", int'(xck_out), p);
         step();
         check("R6 master out toggles after divider tick", int'(xck_out), int'(!p[0]));
      end

      // R8: slave mode, divisor zero so divider would tick every cycle
      xck_in = 1'b0;
      configure(0, 1, 0, 0, 0);
      check("R7 no drive in slave", int'(xck_oe), 0);
      for (int k = 0; k < 5; k++) begin
         step();
         check("R8 no divider ticks in slave", int'(rx_tick | tx_tick), 0);
      end
      slave_edge(1'b1, 1'b1);
      slave_edge(1'b0, 1'b0);
      configure(0, 1, 0, 0, 1);
      repeat (4) step();
      slave_edge(1'b1, 1'b0);
      slave_edge(1'b0, 1'b1);

      // constrained random configurations
      for (int it = 0; it < 12; it++) begin
         int d = $urandom_range(0, 40);
         int m = $urandom_range(0, 2);
         logic db = (m == 1) ? 1'b1 : ((m == 2) ? 1'($urandom_range(0, 1)) : 1'b0);
         logic pl = 1'($urandom_range(0, 1));
         configure(d, m == 2, db, m == 2, pl);
         check("R7 pin enable per mode", int'(xck_oe), (m == 2) ? 1 : 0);
         measure(0, exp_rx_period(m, d), (m == 2) ? "R5 random rx period" : "R1 random rx period");
         measure(1, exp_tx_period(m, d),
                 (m == 0) ? "R3 random tx period" : ((m == 1) ? "R4 random tx period" : "R5 random tx period"));
      end

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule